// File: doc/BRIEF.md
# Cascadable Registered ALU Slice

This block is a 16-bit arithmetic and logic slice that can be chained into wider datapaths. Two operand words enter through their own registers. A select field picks the R and S operands from the A operand, the B operand, zero, or the stored result, which allows accumulation inside the slice. A 3-bit opcode picks one of eight functions: two subtractions and an addition that include a carry input, three bitwise logic functions, and two constant results. The result passes through an output register and drives a port that can be released.

Each register stage has a bypass control. With every stage bypassed the slice is a purely combinational function of its inputs. With no stage bypassed it is a two-stage pipeline. Carry-out, active-low group propagate and generate, two's-complement overflow and a zero flag leave the slice with the result. A ripple chain uses the carry-out. A lookahead unit uses propagate and generate.

Top module: `alu_slice_top`

## Requirements
- R1: A synchronous active-high `rst` clears the A, B and result registers. In the clock after reset, with the result register in use and the port driven, `f_data` reads 0 and `zero` reads 1.
- R2: `src_sel` sets the operands as follows: 00 gives R=A and S=stored result; 01 gives R=A and S=0; 10 gives R=0 and S=B; 11 gives R=A and S=B.
- R3: Opcode 000 yields 0x0000 and opcode 111 yields 0xFFFF. Opcode 100 yields R XOR S, 101 yields R OR S, and 110 yields R AND S.
- R4: Opcode 001 yields S + ~R + carry_in, 010 yields R + ~S + carry_in, and 011 yields R + S + carry_in, each taken modulo 2^16.
- R5: For the three arithmetic opcodes, `carry_out` is the carry out of bit 15 of that sum. `ovf` is 1 exactly when the two addends have the same sign and the sum's sign differs from it.
- R6: For arithmetic opcodes, `gen_n` is 0 exactly when the two addends produce a carry-out with a carry input of 0. `prop_n` is 0 exactly when the addends sum to 0xFFFF. This makes `carry_out` equal to generate OR (propagate AND carry_in).
- R7: For opcodes 000, 100, 101, 110 and 111, `carry_out` and `ovf` are 0, and `prop_n` and `gen_n` are 1.
- R8: `zero` is 1 exactly when the result on the output path is 0x0000. This holds whether or not the port is driven.
- R9: When `bypass_ab` is 0, each operand register loads on a rising edge where its `a_load_n` or `b_load_n` is 0, and otherwise holds. With every stage registered, a new operand reaches `f_data` after the second rising edge.
- R10: When `bypass_ab` is 1, the A and B inputs reach the ALU directly and the load enables have no effect. The operand registers keep their contents, and those contents reappear when the bypass is removed.
- R11: When `bypass_f` is 0, the result register and its carry, propagate, generate and overflow flags load on an edge where `f_load_n` is 0 and otherwise hold. When `bypass_f` is 1, the output path carries the ALU output directly and the register holds.
- R12: With `src_sel` 00, S is the stored result-register value, so repeated additions accumulate in that register one step per edge.
- R13: When `out_hiz` is 1, `f_drive` is 0 and `f_data` reads 0x0000. When `out_hiz` is 0, `f_drive` is 1 and `f_data` carries the output-path result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | A operand |
| b_in | input | 16 | B operand |
| a_load_n | input | 1 | A register load, active low |
| b_load_n | input | 1 | B register load, active low |
| f_load_n | input | 1 | Result register load, active low |
| bypass_ab | input | 1 | Makes both operand registers transparent |
| bypass_f | input | 1 | Makes the result register transparent |
| src_sel | input | 2 | Operand source select |
| op | input | 3 | Function select |
| carry_in | input | 1 | Carry into bit 0 |
| out_hiz | input | 1 | Releases the result port when high |
| f_data | output | 16 | Result port value (0 when released) |
| f_drive | output | 1 | High while the result port is driven |
| carry_out | output | 1 | Carry out of bit 15 |
| prop_n | output | 1 | Group propagate, active low |
| gen_n | output | 1 | Group generate, active low |
| ovf | output | 1 | Two's-complement overflow |
| zero | output | 1 | Result is all zeros |

## Verification
A corrupted operand register appears at `f_data` after two edges in registered mode. A stuck or misloaded register also shows when the bypass is removed and a stale word reappears. A wrong result-register value shows one edge later through accumulation, because it becomes the S operand. Flag errors show in the same cycle as the result, since the flags travel with it and are checked against the carry relation between `carry_out`, `prop_n` and `gen_n`.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    localparam int SLICE_W = 16;

    typedef enum logic [1:0] {
        SRC_A_FB   = 2'b00,
        SRC_A_ZERO = 2'b01,
        SRC_ZERO_B = 2'b10,
        SRC_A_B    = 2'b11
    } src_sel_e;

    typedef enum logic [2:0] {
        OP_CLEAR  = 3'b000,
        OP_S_SUBR = 3'b001,
        OP_R_SUBS = 3'b010,
        OP_ADD    = 3'b011,
        OP_XOR    = 3'b100,
        OP_OR     = 3'b101,
        OP_AND    = 3'b110,
        OP_SET    = 3'b111
    } op_e;

    typedef struct packed {
        logic carry;
        logic prop_n;
        logic gen_n;
        logic ovf;
    } flag_t;

    localparam flag_t FLAGS_IDLE = '{carry: 1'b0, prop_n: 1'b1, gen_n: 1'b1, ovf: 1'b0};

    function automatic logic op_is_arith(input op_e code);
        return (code == OP_S_SUBR) || (code == OP_R_SUBS) || (code == OP_ADD);
    endfunction

endpackage

// File: rtl/operand_reg.sv
module operand_reg
    import alu_slice_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    input  logic         load_n,
    input  logic         bypass,
    output logic [W-1:0] q_path
);
    logic [W-1:0] q_reg;

    always_ff @(posedge clk) begin
        if (rst)
            q_reg <= '0;
        else if (!bypass && !load_n)
            q_reg <= d;
    end

    assign q_path = bypass ? d : q_reg;

    // R9: a deasserted load with the register in use keeps its contents
    assert_opnd_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!bypass && load_n) |=> $stable(q_reg));

    // R10: while bypassed the register is left untouched
    assert_opnd_bypass_hold_R10: assert property (@(posedge clk) disable iff (rst)
        bypass |=> $stable(q_reg));

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_slice_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic [W-1:0] a_op,
    input  logic [W-1:0] b_op,
    input  logic [W-1:0] fb_op,
    input  logic [1:0]   src_sel,
    input  logic [2:0]   op,
    input  logic         carry_in,
    output logic [W-1:0] result,
    output flag_t        flags
);
    localparam logic [W:0] ALL_ONES_EXT = {1'b0, {W{1'b1}}};

    src_sel_e     sel;
    op_e          code;
    logic [W-1:0] r_op, s_op;
    logic [W-1:0] x_add, y_add;
    logic [W:0]   sum_ext, raw_ext;

    assign sel  = src_sel_e'(src_sel);
    assign code = op_e'(op);

    always_comb begin
        unique case (sel)
            SRC_A_FB:   begin r_op = a_op; s_op = fb_op; end
            SRC_A_ZERO: begin r_op = a_op; s_op = '0;    end
            SRC_ZERO_B: begin r_op = '0;   s_op = b_op;  end
            default:    begin r_op = a_op; s_op = b_op;  end
        endcase
    end

    always_comb begin
        unique case (code)
            OP_S_SUBR: begin x_add = ~r_op; y_add = s_op;  end
            OP_R_SUBS: begin x_add = r_op;  y_add = ~s_op; end
            default:   begin x_add = r_op;  y_add = s_op;  end
        endcase
    end

    assign raw_ext = {1'b0, x_add} + {1'b0, y_add};
    assign sum_ext = raw_ext + {{W{1'b0}}, carry_in};

    always_comb begin
        flags = FLAGS_IDLE;
        unique case (code)
            OP_CLEAR: result = '0;
            OP_SET:   result = '1;
            OP_XOR:   result = r_op ^ s_op;
            OP_OR:    result = r_op | s_op;
            OP_AND:   result = r_op & s_op;
            default: begin
                result       = sum_ext[W-1:0];
                flags.carry  = sum_ext[W];
                flags.gen_n  = !(raw_ext > ALL_ONES_EXT);
                flags.prop_n = !(raw_ext == ALL_ONES_EXT);
                flags.ovf    = (x_add[W-1] == y_add[W-1]) && (sum_ext[W-1] != x_add[W-1]);
            end
        endcase
    end

    // R6: generate and propagate are mutually exclusive for one addend pair
    always_comb begin
        assert_pg_exclusive_R6: assert (flags.gen_n || flags.prop_n);
    end

endmodule

// File: rtl/result_reg.sv
module result_reg
    import alu_slice_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         bypass,
    input  logic [W-1:0] d_result,
    input  flag_t        d_flags,
    output logic [W-1:0] path_result,
    output flag_t        path_flags,
    output logic [W-1:0] stored_result
);
    logic [W-1:0] res_q;
    flag_t        flg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            flg_q <= FLAGS_IDLE;
        end else if (!bypass && !load_n) begin
            res_q <= d_result;
            flg_q <= d_flags;
        end
    end

    assign path_result   = bypass ? d_result : res_q;
    assign path_flags    = bypass ? d_flags  : flg_q;
    assign stored_result = res_q;

    // R1: the register leaves reset cleared
    assert_res_reset_R1: assert property (@(posedge clk)
        rst |=> (res_q == '0));

    // R11: register and its flags hold when not loading or bypassed
    assert_res_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (bypass || load_n) |=> ($stable(res_q) && $stable(flg_q)));

endmodule

// File: rtl/alu_slice_top.sv
module alu_slice_top
    import alu_slice_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         a_load_n,
    input  logic         b_load_n,
    input  logic         f_load_n,
    input  logic         bypass_ab,
    input  logic         bypass_f,
    input  logic [1:0]   src_sel,
    input  logic [2:0]   op,
    input  logic         carry_in,
    input  logic         out_hiz,
    output logic [W-1:0] f_data,
    output logic         f_drive,
    output logic         carry_out,
    output logic         prop_n,
    output logic         gen_n,
    output logic         ovf,
    output logic         zero
);
    logic [W-1:0] a_path, b_path, fb_word;
    logic [W-1:0] alu_res, out_res;
    flag_t        alu_flags, out_flags;

    operand_reg #(.W(W)) u_a_reg (
        .clk(clk), .rst(rst), .d(a_in), .load_n(a_load_n),
        .bypass(bypass_ab), .q_path(a_path)
    );

    operand_reg #(.W(W)) u_b_reg (
        .clk(clk), .rst(rst), .d(b_in), .load_n(b_load_n),
        .bypass(bypass_ab), .q_path(b_path)
    );

    alu_core #(.W(W)) u_core (
        .a_op(a_path), .b_op(b_path), .fb_op(fb_word),
        .src_sel(src_sel), .op(op), .carry_in(carry_in),
        .result(alu_res), .flags(alu_flags)
    );

    result_reg #(.W(W)) u_f_reg (
        .clk(clk), .rst(rst), .load_n(f_load_n), .bypass(bypass_f),
        .d_result(alu_res), .d_flags(alu_flags),
        .path_result(out_res), .path_flags(out_flags),
        .stored_result(fb_word)
    );

    assign f_drive   = !out_hiz;
    assign f_data    = out_hiz ? '0 : out_res;
    assign carry_out = out_flags.carry;
    assign prop_n    = out_flags.prop_n;
    assign gen_n     = out_flags.gen_n;
    assign ovf       = out_flags.ovf;
    assign zero      = (out_res == '0);

    // R6: in flow-through, carry-out obeys the lookahead relation
    assert_carry_relation_R6: assert property (@(posedge clk) disable iff (rst)
        (bypass_f && op_is_arith(op_e'(op))) |->
            (carry_out == (!gen_n || (!prop_n && carry_in))));

    // R7: logic functions in flow-through leave the cascade flags idle
    assert_logic_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (bypass_f && !op_is_arith(op_e'(op))) |->
            (!carry_out && !ovf && prop_n && gen_n));

    // R13: a released port shows nothing
    assert_port_release_R13: assert property (@(posedge clk) disable iff (rst)
        out_hiz |-> (!f_drive && (f_data == '0)));

endmodule

// File: tb/alu_slice_top_bench.sv
module alu_slice_top_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic         a_load_n, b_load_n, f_load_n;
    logic         bypass_ab, bypass_f;
    logic [1:0]   src_sel;
    logic [2:0]   op;
    logic         carry_in, out_hiz;
    logic [W-1:0] f_data;
    logic         f_drive, carry_out, prop_n, gen_n, ovf, zero;

    int n_checks = 0;
    int n_fails  = 0;

    alu_slice_top u_alu_slice_top (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .a_load_n(a_load_n), .b_load_n(b_load_n), .f_load_n(f_load_n),
        .bypass_ab(bypass_ab), .bypass_f(bypass_f), .src_sel(src_sel),
        .op(op), .carry_in(carry_in), .out_hiz(out_hiz),
        .f_data(f_data), .f_drive(f_drive), .carry_out(carry_out),
        .prop_n(prop_n), .gen_n(gen_n), .ovf(ovf), .zero(zero)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Expected value for the flow-through path, from R2..R7.
    // Returns {carry, prop_n, gen_n, ovf, result}
    function automatic logic [W+3:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic [W-1:0] fb, input logic [1:0] sel,
                                            input logic [2:0] code, input logic cin);
        logic [W-1:0] r, s, x, y;
        logic [W:0]   pair, tot;
        r = (sel == 2'b10) ? '0 : a;
        s = (sel == 2'b00) ? fb : (sel == 2'b01) ? '0 : b;
        case (code)
            3'b000: return {4'b0110, {W{1'b0}}};
            3'b111: return {4'b0110, {W{1'b1}}};
            3'b100: return {4'b0110, r ^ s};
            3'b101: return {4'b0110, r | s};
            3'b110: return {4'b0110, r & s};
            default: begin
                x = (code == 3'b001) ? ~r : r;
                y = (code == 3'b010) ? ~s : s;
                pair = x + y;
                tot  = pair + cin;
                return {tot[W], !(pair == {1'b0, {W{1'b1}}}), !pair[W],
                        (x[W-1] == y[W-1]) && (tot[W-1] != x[W-1]), tot[W-1:0]};
            end
        endcase
    endfunction

    task automatic flow_case(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                             input logic [1:0] sel, input logic [2:0] code, input logic cin);
        logic [W+3:0] e;
        @(negedge clk);
        a_in = a; b_in = b; src_sel = sel; op = code; carry_in = cin;
        #1;
        e = model(a, b, '0, sel, code, cin);
        check({tag, " result"}, 32'(f_data), 32'(e[W-1:0]));
        check({tag, " flags"}, 32'({carry_out, prop_n, gen_n, ovf}), 32'(e[W+3:W]));
        check({tag, " zero R8"}, 32'(zero), 32'(e[W-1:0] == '0));
    endtask

    task automatic t_reset_R1;
        rst = 1'b1; a_in = 16'h1111; b_in = 16'h2222;
        a_load_n = 1'b0; b_load_n = 1'b0; f_load_n = 1'b0;
        bypass_ab = 1'b0; bypass_f = 1'b0; src_sel = 2'b11; op = 3'b011;
        carry_in = 1'b0; out_hiz = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 f_data after reset", 32'(f_data), 32'h0);
        check("R1 zero after reset", 32'(zero), 32'h1);
        check("R1 drive after reset", 32'(f_drive), 32'h1);
        rst = 1'b0;
    endtask

    task automatic t_flow_functions;
        bypass_ab = 1'b1; bypass_f = 1'b1;
        flow_case("R4 add", 16'h1234, 16'h0111, 2'b11, 3'b011, 1'b1);
        flow_case("R5 add overflow", 16'h7FFF, 16'h0001, 2'b11, 3'b011, 1'b0);
        flow_case("R5 add carry wraps", 16'hFFFF, 16'h0001, 2'b11, 3'b011, 1'b0);
        flow_case("R4 r minus s", 16'h0005, 16'h0003, 2'b11, 3'b010, 1'b1);
        flow_case("R4 s minus r", 16'h0005, 16'h0003, 2'b11, 3'b001, 1'b1);
        flow_case("R5 sub overflow", 16'h8000, 16'h0001, 2'b11, 3'b010, 1'b1);
        flow_case("R6 propagate c0", 16'h00FF, 16'hFF00, 2'b11, 3'b011, 1'b0);
        flow_case("R6 propagate c1", 16'h00FF, 16'hFF00, 2'b11, 3'b011, 1'b1);
        flow_case("R6 generate", 16'h8000, 16'h8000, 2'b11, 3'b011, 1'b0);
        flow_case("R3 xor", 16'hF0F0, 16'h3C3C, 2'b11, 3'b100, 1'b1);
        flow_case("R3 or R7", 16'hF0F0, 16'h3C3C, 2'b11, 3'b101, 1'b1);
        flow_case("R3 and", 16'hF0F0, 16'h3C3C, 2'b11, 3'b110, 1'b0);
        flow_case("R3 clear", 16'hFFFF, 16'hFFFF, 2'b11, 3'b000, 1'b1);
        flow_case("R3 set", 16'h0000, 16'h0000, 2'b11, 3'b111, 1'b0);
        flow_case("R2 sel01", 16'hABCD, 16'h1357, 2'b01, 3'b100, 1'b0);
        flow_case("R2 sel10", 16'hABCD, 16'h1357, 2'b10, 3'b100, 1'b0);
        flow_case("R2 sel00", 16'hABCD, 16'h1357, 2'b00, 3'b100, 1'b0);
        // hand-computed anchors
        flow_case("R4 anchor", 16'h0005, 16'h0003, 2'b11, 3'b001, 1'b1);
        check("R4 s minus r literal", 32'(f_data), 32'hFFFE);
        check("R5 s minus r no carry", 32'(carry_out), 32'h0);
    endtask

    task automatic t_hiz_R13;
        @(negedge clk);
        a_in = 16'h0000; b_in = 16'h0000; src_sel = 2'b11; op = 3'b111; out_hiz = 1'b1;
        #1;
        check("R13 released drive", 32'(f_drive), 32'h0);
        check("R13 released data", 32'(f_data), 32'h0);
        check("R8 zero while released", 32'(zero), 32'h0);
        @(negedge clk);
        out_hiz = 1'b0;
        #1;
        check("R13 driven data", 32'(f_data), 32'hFFFF);
    endtask

    task automatic t_pipeline_R9;
        @(negedge clk);
        bypass_ab = 1'b0; bypass_f = 1'b0; f_load_n = 1'b0;
        a_load_n = 1'b0; b_load_n = 1'b0;
        a_in = 16'd10; b_in = 16'd20; src_sel = 2'b11; op = 3'b011; carry_in = 1'b0;
        @(posedge clk); #2;
        check("R9 not yet at output", 32'(f_data == 16'd30), 32'h0);
        @(posedge clk); #2;
        check("R9 two-edge latency", 32'(f_data), 32'd30);
        @(negedge clk);
        a_load_n = 1'b1; a_in = 16'd99;
        repeat (2) @(posedge clk); #2;
        check("R9 A held", 32'(f_data), 32'd30);
        @(negedge clk);
        a_load_n = 1'b0; a_in = 16'hFFFF; b_in = 16'h0001;
        repeat (2) @(posedge clk); #2;
        check("R11 registered result", 32'(f_data), 32'h0);
        check("R11 registered carry", 32'(carry_out), 32'h1);
        check("R8 registered zero", 32'(zero), 32'h1);
    endtask

    task automatic t_fhold_R11;
        @(negedge clk);
        f_load_n = 1'b1; a_in = 16'h0100; b_in = 16'h0200;
        repeat (3) @(posedge clk); #2;
        check("R11 hold result", 32'(f_data), 32'h0);
        check("R11 hold carry", 32'(carry_out), 32'h1);
        @(negedge clk);
        f_load_n = 1'b0;
        @(posedge clk); #2;
        check("R11 load resumes", 32'(f_data), 32'h0300);
        check("R11 carry updated", 32'(carry_out), 32'h0);
    endtask

    task automatic t_accum_R12;
        @(negedge clk);
        bypass_ab = 1'b1; bypass_f = 1'b0; f_load_n = 1'b0;
        op = 3'b000; a_in = 16'd5; carry_in = 1'b0; src_sel = 2'b00;
        @(posedge clk); #2;
        check("R12 cleared", 32'(f_data), 32'd0);
        @(negedge clk);
        op = 3'b011;
        for (int k = 1; k <= 3; k++) begin
            @(posedge clk); #2;
            check("R12 accumulate", 32'(f_data), 32'(5 * k));
        end
    endtask

    task automatic t_bypass_R10;
        @(negedge clk);
        bypass_ab = 1'b0; bypass_f = 1'b1; a_load_n = 1'b0;
        a_in = 16'h1234; src_sel = 2'b01; op = 3'b011; carry_in = 1'b0;
        @(posedge clk); #2;
        check("R10 registered A", 32'(f_data), 32'h1234);
        @(negedge clk);
        bypass_ab = 1'b1; a_in = 16'h5555;
        #1;
        check("R10 transparent A", 32'(f_data), 32'h5555);
        repeat (2) @(posedge clk);
        @(negedge clk);
        bypass_ab = 1'b0; a_load_n = 1'b1;
        #1;
        check("R10 register untouched", 32'(f_data), 32'h1234);
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset_R1();
        t_flow_functions();
        t_hiz_R13();
        t_pipeline_R9();
        t_fhold_R11();
        t_accum_R12();
        t_bypass_R10();
        repeat (2) @(posedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule